// File: doc/BRIEF.md
# Serial NOR Flash Read/Erase Sequencer

This block sits on the controller side of a single serial NOR flash device and turns one request into the full series of byte frames the device needs. A request names an operation (read or erase), a 24-bit byte address, a byte count and, for reads, whether the fast variant with a dummy byte is used. For erases it also names the erase granule. The block drives the four SPI wires in mode 0. It returns read data as a byte stream with a one-cycle strobe, and it ends every request with a one-cycle completion pulse carrying an error code.

Every accepted operation first reads the device status repeatedly until the busy bit clears. The number of status reads is bounded; when the bound runs out the request ends with a timeout. An erase covering several granules repeats the sequence once per granule: status wait, then write-enable, then the erase frame. The address steps by the granule size each time. Requests that are misaligned or run past the end of the device are refused before the bus is touched.

Top module: `spi_nor_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `req_ready` is 1 and `done` is 0.
- R2: SPI mode 0: `spi_sclk` rests low and toggles only while `spi_cs_n` is 0; bytes go out MSB first, MOSI changes after falling edges and MISO is sampled on rising edges.
- R3: Every accepted request with a non-zero length that passes the checks begins with status frames: byte 0x05, then one byte read back. The frame repeats while bit 0 (busy) of the returned byte is 1.
- R4: If POLL_LIMIT status frames in a row all report busy, the request ends with `err` = 2 (timeout) and no further frame. A clear status on the POLL_LIMIT-th frame still succeeds.
- R5: An erase granule is a one-byte frame 0x06, then a four-byte frame of the erase opcode and the address, high byte first.
- R6: `req_esel` picks the granule: 0 gives opcode 0x20 and 4096 bytes, 1 gives 0x52 and 32768 bytes, 2 gives 0xD8 and 65536 bytes. The value 3 is refused with `err` = 1.
- R7: A multi-granule erase issues one status-wait/write-enable/erase sequence per granule, with the address advancing by the granule size. A timeout in any wait ends the request with `err` = 2 and issues no later erase frame.
- R8: A normal read (`req_fast` = 0) sends 0x03 and three address bytes, high byte first. It then delivers `req_len` bytes on `rd_data` with `rd_valid`, in address order, and ends with `err` = 0.
- R9: A fast read (`req_fast` = 1) sends 0x0B, three address bytes and one dummy byte before the data bytes are captured.
- R10: A request is refused with `err` = 1 and no bus activity when `req_addr + req_len` exceeds DEV_BYTES, or when it is an erase whose address or length is not a multiple of the granule. A request ending exactly at DEV_BYTES is accepted.
- R11: A request with `req_len` = 0 completes with `done` and `err` = 0 and never lowers `spi_cs_n`. This check comes before all others.
- R12: Between two frames `spi_cs_n` stays high for at least one SPI clock period (2*CLK_DIV clock cycles).
- R13: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its `done` pulse. `req_valid` during that time has no effect, and `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid is high |
| req_erase | input | 1 | 1 = erase, 0 = read |
| req_fast | input | 1 | Read uses fast variant with dummy byte |
| req_esel | input | 2 | Erase granule select (0: 4 KiB, 1: 32 KiB, 2: 64 KiB) |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Byte count |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Completion code: 0 ok, 1 refused, 2 timeout |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Controller-to-flash data |
| spi_miso | input | 1 | Flash-to-controller data |

## Verification
The hardest states to reach are the busy-status branches: the timeout that strikes partway through a multi-granule erase, and the poll that clears on exactly the last allowed try. No request field can cause them directly. The bench therefore models the flash behind the SPI wires. The model answers status reads busy for a programmable number of polls and re-arms that count after every erase frame, so the bench can choose which poll of which granule sees busy. With a small POLL_LIMIT the bench reaches both the last-try success and the timeout in the second granule, and it confirms them from the frame log that the model records.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    typedef enum logic [1:0] {
        PH_POLL  = 2'd0,
        PH_WREN  = 2'd1,
        PH_ERASE = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_REJECT  = 2'd1,
        ERR_TIMEOUT = 2'd2
    } err_e;

    typedef struct packed {
        logic        erase;
        logic        fast;
        logic [1:0]  esel;
        logic [23:0] addr;
    } req_t;

    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_WEN    = 8'h06;
    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_FREAD  = 8'h0B;

    function automatic logic [7:0] erase_opcode(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'h20;
            2'd1:    return 8'h52;
            default: return 8'hD8;
        endcase
    endfunction

    function automatic logic [4:0] erase_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd12;
            2'd1:    return 5'd15;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [2:0] header_len(input phase_e ph, input logic fast);
        case (ph)
            PH_ERASE: return 3'd4;
            PH_READ:  return fast ? 3'd5 : 3'd4;
            default:  return 3'd1;
        endcase
    endfunction

    function automatic logic [7:0] header_byte(input phase_e ph, input logic [2:0] idx,
                                               input logic fast, input logic [1:0] sel,
                                               input logic [23:0] addr);
        logic [7:0] opc;
        case (ph)
            PH_POLL:  opc = OPC_STATUS;
            PH_WREN:  opc = OPC_WEN;
            PH_ERASE: opc = erase_opcode(sel);
            default:  opc = fast ? OPC_FREAD : OPC_READ;
        endcase
        case (idx)
            3'd0:    return opc;
            3'd1:    return addr[23:16];
            3'd2:    return addr[15:8];
            3'd3:    return addr[7:0];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

    logic             active, phase_hi, sclk_q, done_q;
    logic [2:0]       bit_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [7:0]       shreg, rxreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            phase_hi <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            bit_cnt  <= '0;
            div_cnt  <= '0;
            shreg    <= '0;
            rxreg    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !active) begin
                active   <= 1'b1;
                shreg    <= tx_byte;
                bit_cnt  <= '0;
                div_cnt  <= '0;
                phase_hi <= 1'b0;
                sclk_q   <= 1'b0;
            end else if (active) begin
                if (div_cnt == DIV_W'(HALF_DIV - 1)) begin
                    div_cnt <= '0;
                    if (!phase_hi) begin
                        sclk_q   <= 1'b1;
                        phase_hi <= 1'b1;
                        rxreg    <= {rxreg[6:0], miso};
                    end else begin
                        sclk_q   <= 1'b0;
                        phase_hi <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            shreg   <= {shreg[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = active ? shreg[7] : 1'b0;
    assign done    = done_q;
    assign rx_byte = rxreg;

    // R2: a byte ends on a falling clock edge
    assert_byte_end_R2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(sclk_q));

endmodule

// File: rtl/nor_req_check.sv
module nor_req_check
    import spi_nor_pkg::*;
#(
    parameter int LEN_W     = 24,
    parameter int DEV_BYTES = 1 << 20
) (
    input  req_t             req,
    input  logic [LEN_W-1:0] len,
    output logic             empty,
    output logic             reject
);
    logic [32:0] end_sum;
    logic [23:0] gran_mask;
    logic        misalign, bad_sel, overrun;

    always_comb begin
        end_sum   = 33'(req.addr) + 33'(len);
        gran_mask = (24'd1 << erase_shift(req.esel)) - 24'd1;
        bad_sel   = req.erase && (req.esel == 2'd3);
        misalign  = req.erase && (((req.addr & gran_mask) != '0) ||
                                  ((33'(len) & 33'(gran_mask)) != '0));
        overrun   = end_sum > 33'(DEV_BYTES);
        empty     = (len == '0);
        reject    = !empty && (bad_sel || misalign || overrun);
    end

endmodule

// File: rtl/nor_op_sequencer.sv
module nor_op_sequencer
    import spi_nor_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int POLL_LIMIT = 100000,
    parameter int GAP_CYC    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  req_t             req_in,
    input  logic [LEN_W-1:0] req_len,
    input  logic             chk_empty,
    input  logic             chk_reject,
    output logic             req_ready,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx,
    output logic             cs_n,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output err_e             err
);
    localparam int FL_W = LEN_W + 3;
    localparam int PCW  = $clog2(POLL_LIMIT + 1);
    localparam int GCW  = $clog2(GAP_CYC + 1);

    state_e           st;
    phase_e           ph;
    req_t             req_q;
    logic [23:0]      cur_addr, esize;
    logic [LEN_W-1:0] remain;
    logic [FL_W-1:0]  frame_left;
    logic [2:0]       idx, hdr_len;
    logic             inflight, busy_q, cs_n_q, rdv_q;
    logic [7:0]       rdd_q;
    logic [PCW-1:0]   poll_cnt;
    logic [GCW-1:0]   gap_cnt;
    err_e             err_q;

    logic   gap_end, g_launch, g_fin, g_step, g_poll_inc, g_poll_clr;
    phase_e g_ph;
    err_e   g_err;

    function automatic logic [FL_W-1:0] frame_len(input phase_e p, input logic fast,
                                                  input logic [LEN_W-1:0] n);
        case (p)
            PH_POLL:  return FL_W'(2);
            PH_WREN:  return FL_W'(1);
            PH_ERASE: return FL_W'(4);
            default:  return FL_W'(header_len(PH_READ, fast)) + FL_W'(n);
        endcase
    endfunction

    assign esize     = 24'd1 << erase_shift(req_q.esel);
    assign hdr_len   = header_len(ph, req_q.fast);
    assign eng_start = (st == ST_XFER) && !inflight;
    assign eng_tx    = (idx < hdr_len) ? header_byte(ph, idx, req_q.fast, req_q.esel, cur_addr)
                                       : 8'h00;
    assign gap_end   = (st == ST_GAP) && (gap_cnt == GCW'(GAP_CYC - 1));

    always_comb begin
        g_launch   = 1'b0;
        g_fin      = 1'b0;
        g_step     = 1'b0;
        g_poll_inc = 1'b0;
        g_poll_clr = 1'b0;
        g_ph       = PH_POLL;
        g_err      = ERR_NONE;
        case (ph)
            PH_POLL: begin
                if (!busy_q) begin
                    g_launch   = 1'b1;
                    g_poll_clr = 1'b1;
                    g_ph       = req_q.erase ? PH_WREN : PH_READ;
                end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                    g_fin = 1'b1;
                    g_err = ERR_TIMEOUT;
                end else begin
                    g_launch   = 1'b1;
                    g_poll_inc = 1'b1;
                end
            end
            PH_WREN: begin
                g_launch = 1'b1;
                g_ph     = PH_ERASE;
            end
            PH_ERASE: begin
                if (remain == LEN_W'(esize)) begin
                    g_fin = 1'b1;
                end else begin
                    g_step   = 1'b1;
                    g_launch = 1'b1;
                end
            end
            default: g_fin = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ph         <= PH_POLL;
            req_q      <= '0;
            cur_addr   <= '0;
            remain     <= '0;
            frame_left <= '0;
            idx        <= '0;
            inflight   <= 1'b0;
            busy_q     <= 1'b0;
            cs_n_q     <= 1'b1;
            rdv_q      <= 1'b0;
            rdd_q      <= '0;
            poll_cnt   <= '0;
            gap_cnt    <= '0;
            err_q      <= ERR_NONE;
        end else begin
            rdv_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q    <= req_in;
                        cur_addr <= req_in.addr;
                        remain   <= req_len;
                        poll_cnt <= '0;
                        if (chk_empty) begin
                            st    <= ST_DONE;
                            err_q <= ERR_NONE;
                        end else if (chk_reject) begin
                            st    <= ST_DONE;
                            err_q <= ERR_REJECT;
                        end else begin
                            st         <= ST_XFER;
                            ph         <= PH_POLL;
                            idx        <= '0;
                            frame_left <= frame_len(PH_POLL, 1'b0, '0);
                            cs_n_q     <= 1'b0;
                        end
                    end
                end
                ST_XFER: begin
                    if (!inflight) begin
                        inflight <= 1'b1;
                    end else if (eng_done) begin
                        inflight   <= 1'b0;
                        frame_left <= frame_left - FL_W'(1);
                        if (idx != 3'd7) idx <= idx + 3'd1;
                        if (ph == PH_POLL && idx == 3'd1) busy_q <= eng_rx[0];
                        if (ph == PH_READ && idx >= hdr_len) begin
                            rdv_q <= 1'b1;
                            rdd_q <= eng_rx;
                        end
                        if (frame_left == FL_W'(1)) begin
                            st      <= ST_GAP;
                            cs_n_q  <= 1'b1;
                            gap_cnt <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_end) begin
                        if (g_poll_inc) poll_cnt <= poll_cnt + PCW'(1);
                        if (g_poll_clr) poll_cnt <= '0;
                        if (g_step) begin
                            remain   <= remain - LEN_W'(esize);
                            cur_addr <= cur_addr + esize;
                        end
                        if (g_fin) begin
                            st    <= ST_DONE;
                            err_q <= g_err;
                        end else if (g_launch) begin
                            st         <= ST_XFER;
                            ph         <= g_ph;
                            idx        <= '0;
                            frame_left <= frame_len(g_ph, req_q.fast, remain);
                            cs_n_q     <= 1'b0;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + GCW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign done      = (st == ST_DONE);
    assign err       = err_q;
    assign cs_n      = cs_n_q;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;

    // R13: an accepted request closes the handshake until completion
    assert_req_blocked_R13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R13: completion is a single-cycle pulse
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: the poll counter never reaches the limit
    assert_poll_bound_R4: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < PCW'(POLL_LIMIT));

    // R12: chip select holds high for more than one cycle after a frame
    assert_gap_hold_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

    // R8: read bytes come only from a frame that was in progress
    assert_rd_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!cs_n));

endmodule

// File: rtl/spi_nor_seq.sv
module spi_nor_seq
    import spi_nor_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int POLL_LIMIT = 100000,
    parameter int DEV_BYTES  = 1 << 20,
    parameter int LEN_W      = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_erase,
    input  logic             req_fast,
    input  logic [1:0]       req_esel,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic [1:0]       err,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int GAP_CYC = 2 * CLK_DIV;

    req_t       req_bus;
    logic       chk_empty, chk_reject;
    logic       eng_start, eng_done;
    logic [7:0] eng_tx, eng_rx;
    err_e       err_code;

    assign req_bus = '{erase: req_erase, fast: req_fast, esel: req_esel, addr: req_addr};

    nor_req_check #(.LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)) u_check (
        .req    (req_bus),
        .len    (req_len),
        .empty  (chk_empty),
        .reject (chk_reject)
    );

    nor_op_sequencer #(.LEN_W(LEN_W), .POLL_LIMIT(POLL_LIMIT), .GAP_CYC(GAP_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_bus),
        .req_len    (req_len),
        .chk_empty  (chk_empty),
        .chk_reject (chk_reject),
        .req_ready  (req_ready),
        .eng_start  (eng_start),
        .eng_tx     (eng_tx),
        .eng_done   (eng_done),
        .eng_rx     (eng_rx),
        .cs_n       (spi_cs_n),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .done       (done),
        .err        (err_code)
    );

    spi_byte_engine #(.HALF_DIV(CLK_DIV)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    assign err = err_code;

    // R2: the serial clock moves only inside a selected frame
    assert_sclk_framed_R2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/test_spi_nor_seq.sv
module test_spi_nor_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 2;
    localparam int PLIM = 4;
    localparam int DEV  = 1 << 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_erase = 1'b0, req_fast = 1'b0;
    logic [1:0]  req_esel = 2'd0;
    logic [23:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic        req_ready, rd_valid, done;
    logic [7:0]  rd_data;
    logic [1:0]  err;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int nchecks = 0;
    int nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_nor_seq #(.CLK_DIV(DIV), .POLL_LIMIT(PLIM), .DEV_BYTES(DEV), .LEN_W(24)) i_spi_nor_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_fast(req_fast), .req_esel(req_esel),
        .req_addr(req_addr), .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err(err), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // ---------------- flash model ----------------
    int          bitc = 0, bytec = 0;
    int          busy_left = 0, erase_busy = 0;
    logic        wel = 1'b0;
    logic [7:0]  rxs = '0, txs = '0, nxt = '0, f_op = '0;
    logic [23:0] f_addr = '0;
    logic [7:0]  fr_op   [0:63];
    logic [23:0] fr_addr [0:63];
    int          fr_len  [0:63];
    int          nfr = 0;

    always @(negedge cs_n) begin
        bitc  = 0;
        bytec = 0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            rxs  = {rxs[6:0], mosi};
            bitc = bitc + 1;
            if (bitc == 8) begin
                bitc = 0;
                if (bytec == 0) f_op = rxs;
                else if (bytec <= 3) f_addr = {f_addr[15:0], rxs};
                nxt = 8'h00;
                if (f_op == 8'h05 && bytec == 0) begin
                    nxt = {6'b0, wel, busy_left > 0};
                    if (busy_left > 0) busy_left = busy_left - 1;
                end else if (f_op == 8'h03 && bytec >= 3) begin
                    nxt = pat(f_addr + 24'(bytec - 3));
                end else if (f_op == 8'h0B && bytec >= 4) begin
                    nxt = pat(f_addr + 24'(bytec - 4));
                end
                bytec = bytec + 1;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (bitc == 0) begin
                miso <= nxt[7];
                txs  <= {nxt[6:0], 1'b0};
            end else begin
                miso <= txs[7];
                txs  <= {txs[6:0], 1'b0};
            end
        end
    end

    always @(posedge cs_n) begin
        if (bytec > 0 && nfr < 64) begin
            fr_op[nfr]   = f_op;
            fr_addr[nfr] = f_addr;
            fr_len[nfr]  = bytec;
            nfr = nfr + 1;
            if (f_op == 8'h06) wel = 1'b1;
            if (f_op == 8'h20 || f_op == 8'h52 || f_op == 8'hD8) begin
                wel = 1'b0;
                busy_left = erase_busy;
            end
        end
        bytec = 0;
    end

    // ---------------- monitors ----------------
    logic [7:0] rxbuf [0:63];
    int nrx = 0;
    int gap = 100, bad_gap = 0, bad_sclk = 0;

    always @(negedge clk) begin
        if (rd_valid && nrx < 64) begin
            rxbuf[nrx] = rd_data;
            nrx = nrx + 1;
        end
        if (cs_n === 1'b1 && sclk === 1'b1) bad_sclk = bad_sclk + 1;
        if (cs_n === 1'b1) gap = gap + 1;
        else begin
            if (gap != 0 && gap < 2 * DIV) bad_gap = bad_gap + 1;
            gap = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        nchecks = nchecks + 1;
        if (act != exp) begin
            nerr = nerr + 1;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input logic er, input logic fs, input logic [1:0] sel,
                          input logic [23:0] a, input int n,
                          output logic [1:0] e, output int leak);
        nfr = 0;
        nrx = 0;
        leak = 0;
        @(negedge clk);
        req_erase = er; req_fast = fs; req_esel = sel; req_addr = a; req_len = 24'(n);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) begin
            if (req_ready) leak = leak + 1;
            @(negedge clk);
        end
        e = err;
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "cs_n", cs_n, 1);
        chk("R1", "sclk", sclk, 0);
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "done", done, 0);
    endtask

    task automatic t_read_normal();
        logic [1:0] e; int lk;
        busy_left = 2;
        run_op(1'b0, 1'b0, 2'd0, 24'h012345, 5, e, lk);
        chk("R8", "err", e, 0);
        chk("R3", "frame count", nfr, 4);
        for (int i = 0; i < 3; i++) chk("R3", "status opcode", fr_op[i], 8'h05);
        chk("R3", "status frame bytes", fr_len[0], 2);
        chk("R8", "read opcode", fr_op[3], 8'h03);
        chk("R8", "read addr", fr_addr[3], 24'h012345);
        chk("R8", "read frame bytes", fr_len[3], 9);
        chk("R8", "byte count", nrx, 5);
        for (int i = 0; i < 5; i++) chk("R8", "data", rxbuf[i], pat(24'h012345 + 24'(i)));
        chk("R13", "ready leak", lk, 0);
    endtask

    task automatic t_read_fast();
        logic [1:0] e; int lk;
        busy_left = 0;
        run_op(1'b0, 1'b1, 2'd0, 24'h0000FE, 3, e, lk);
        chk("R9", "err", e, 0);
        chk("R9", "frame count", nfr, 2);
        chk("R9", "opcode", fr_op[1], 8'h0B);
        chk("R9", "frame bytes", fr_len[1], 8);
        chk("R9", "byte count", nrx, 3);
        for (int i = 0; i < 3; i++) chk("R9", "data", rxbuf[i], pat(24'h0000FE + 24'(i)));
    endtask

    task automatic t_erase_multi();
        logic [1:0] e; int lk;
        logic [7:0] exp_op [0:6];
        exp_op = '{8'h05, 8'h06, 8'h20, 8'h05, 8'h05, 8'h06, 8'h20};
        busy_left = 0; erase_busy = 1;
        run_op(1'b1, 1'b0, 2'd0, 24'h002000, 24'h2000, e, lk);
        chk("R7", "err", e, 0);
        chk("R7", "frame count", nfr, 7);
        for (int i = 0; i < 7; i++) chk("R7", "op sequence", fr_op[i], exp_op[i]);
        chk("R5", "wren bytes", fr_len[1], 1);
        chk("R5", "erase bytes", fr_len[2], 4);
        chk("R5", "erase addr 1", fr_addr[2], 24'h002000);
        chk("R7", "erase addr 2", fr_addr[6], 24'h003000);
        erase_busy = 0;
        busy_left = 0;
    endtask

    task automatic t_erase_sel();
        logic [1:0] e; int lk;
        busy_left = 0;
        run_op(1'b1, 1'b0, 2'd1, 24'h008000, 24'h8000, e, lk);
        chk("R6", "32K err", e, 0);
        chk("R6", "32K opcode", fr_op[2], 8'h52);
        chk("R6", "32K frames", nfr, 3);
        run_op(1'b1, 1'b0, 2'd2, 24'h010000, 24'h10000, e, lk);
        chk("R6", "64K opcode", fr_op[2], 8'hD8);
        chk("R6", "64K addr", fr_addr[2], 24'h010000);
        run_op(1'b1, 1'b0, 2'd3, 24'h000000, 24'h1000, e, lk);
        chk("R6", "sel 3 err", e, 1);
        chk("R6", "sel 3 frames", nfr, 0);
    endtask

    task automatic t_reject();
        logic [1:0] e; int lk;
        busy_left = 0;
        run_op(1'b1, 1'b0, 2'd0, 24'h001001, 24'h1000, e, lk);
        chk("R10", "misaligned addr err", e, 1);
        chk("R10", "misaligned addr frames", nfr, 0);
        run_op(1'b1, 1'b0, 2'd0, 24'h001000, 24'h0800, e, lk);
        chk("R10", "misaligned len err", e, 1);
        run_op(1'b0, 1'b0, 2'd0, 24'h0FFFFF, 2, e, lk);
        chk("R10", "read overrun err", e, 1);
        chk("R10", "read overrun frames", nfr, 0);
        run_op(1'b1, 1'b0, 2'd2, 24'h0F0000, 24'h20000, e, lk);
        chk("R10", "erase overrun err", e, 1);
        run_op(1'b0, 1'b0, 2'd0, 24'h0FFFFF, 1, e, lk);
        chk("R10", "last byte err", e, 0);
        chk("R10", "last byte count", nrx, 1);
        chk("R10", "last byte data", rxbuf[0], pat(24'h0FFFFF));
    endtask

    task automatic t_zero();
        logic [1:0] e; int lk;
        run_op(1'b0, 1'b0, 2'd0, 24'h000100, 0, e, lk);
        chk("R11", "err", e, 0);
        chk("R11", "frames", nfr, 0);
        chk("R11", "bytes", nrx, 0);
    endtask

    task automatic t_timeout();
        logic [1:0] e; int lk;
        busy_left = 10;
        run_op(1'b0, 1'b0, 2'd0, 24'h000040, 2, e, lk);
        chk("R4", "timeout err", e, 2);
        chk("R4", "poll frames", nfr, PLIM);
        chk("R4", "no data", nrx, 0);
        busy_left = PLIM - 1;
        run_op(1'b0, 1'b0, 2'd0, 24'h000040, 1, e, lk);
        chk("R4", "last-try err", e, 0);
        chk("R4", "last-try frames", nfr, PLIM + 1);
        chk("R4", "last-try read op", fr_op[PLIM], 8'h03);
    endtask

    task automatic t_erase_timeout();
        logic [1:0] e; int lk; int n20;
        busy_left = 0; erase_busy = 10;
        run_op(1'b1, 1'b0, 2'd0, 24'h000000, 24'h2000, e, lk);
        chk("R7", "timeout err", e, 2);
        chk("R7", "frames", nfr, 3 + PLIM);
        n20 = 0;
        for (int i = 0; i < nfr; i++) if (fr_op[i] == 8'h20) n20 = n20 + 1;
        chk("R7", "erase frames", n20, 1);
        erase_busy = 0;
        busy_left = 0;
    endtask

    task automatic t_ignore_busy();
        int lk = 0;
        busy_left = 0;
        nfr = 0; nrx = 0;
        @(negedge clk);
        req_erase = 1'b0; req_fast = 1'b0; req_esel = 2'd0; req_addr = 24'h000100; req_len = 24'd2;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_erase = 1'b1; req_esel = 2'd0; req_addr = 24'h004000; req_len = 24'h1000;
        for (int i = 0; i < 40; i++) begin
            if (req_ready) lk = lk + 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!done) begin
            if (req_ready) lk = lk + 1;
            @(negedge clk);
        end
        @(negedge clk);
        chk("R13", "ready while busy", lk, 0);
        chk("R13", "frames", nfr, 2);
        chk("R13", "second frame op", fr_op[1], 8'h03);
        chk("R13", "bytes", nrx, 2);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchecks = nchecks + 1;
        nerr = nerr + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_normal();
        t_read_fast();
        t_erase_multi();
        t_erase_sel();
        t_reject();
        t_zero();
        t_timeout();
        t_erase_timeout();
        t_ignore_busy();
        chk("R2", "sclk outside frame", bad_sclk, 0);
        chk("R12", "short cs gaps", bad_gap, 0);
        finish_run();
    end

endmodule